// File: doc/BRIEF.md
# Decode Hazard Stall Controller

This block guards the decode stage of an in-order five-stage pipeline against read-after-write data hazards. It compares the register indices that the instruction in decode reads against the destinations of the two older instructions that have not yet written back, in the execute and memory stages. When one of those instructions will write a register the decode instruction needs, the block holds the program counter and the fetch/decode register and turns the decode slot into a bubble. The bubble then moves down the pipeline and behaves as a no-op.

The register file writes before it reads within a cycle, so a producer that has reached writeback never causes a stall. A one-bit policy input picks how the block treats hazards. With stall-only policy, every hazard stalls. With forwarding policy, bypass paths supply results, so the block stalls only when the execute-stage instruction is a load that the decode instruction depends on. The hold outputs are purely combinational. They act on the same clock edge that would otherwise advance the front of the pipeline.

Top module: `hz_stall_ctrl`

## Requirements
- R1: With policy_mode = 0 (stall-only), a used decode source that equals ex_dst while ex_wen = 1 drives a stall: pc_we = 0, ifid_we = 0, idex_bubble = 1.
- R2: With policy_mode = 0, a used decode source that equals mem_dst while mem_wen = 1 drives the same stall.
- R3: When no used, nonzero source matches a writing EX or MEM destination, the outputs are pc_we = 1, ifid_we = 1, idex_bubble = 0. A producer in writeback is not an input and never stalls.
- R4: A source index of 0 never causes a stall, whatever the producer fields hold.
- R5: A source whose use flag (src_a_used or src_b_used) is 0 never causes a stall, even if its index matches.
- R6: A producer whose write enable is 0 never causes a stall, even if its destination matches.
- R7: With policy_mode = 1 (forwarding), a used nonzero source that equals ex_dst while ex_wen = 1 and ex_load = 1 drives a stall.
- R8: With policy_mode = 1, a match against a non-load EX instruction or against the MEM stage causes no stall.
- R9: pc_we and ifid_we are always equal, and idex_bubble is always their complement.
- R10: In stall-only mode, a consumer that directly follows its producer sees two stall cycles (producer in EX, then in MEM) and then proceeds. In forwarding mode, a consumer that directly follows a load sees exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| policy_mode | input | 1 | 0 = stall on every hazard, 1 = forwarding present, stall only on load-use |
| src_a | input | IDX_W | First source register index of the decode instruction |
| src_a_used | input | 1 | Decode instruction reads src_a |
| src_b | input | IDX_W | Second source register index of the decode instruction |
| src_b_used | input | 1 | Decode instruction reads src_b |
| ex_dst | input | IDX_W | Destination index of the EX-stage instruction |
| ex_wen | input | 1 | EX-stage instruction writes a register |
| ex_load | input | 1 | EX-stage instruction is a load |
| mem_dst | input | IDX_W | Destination index of the MEM-stage instruction |
| mem_wen | input | 1 | MEM-stage instruction writes a register |
| pc_we | output | 1 | Program counter may update |
| ifid_we | output | 1 | Fetch/decode register may update |
| idex_bubble | output | 1 | Replace the instruction entering EX with a no-op |

## Verification
The hardest case to reach from the ports is a two-cycle stall that follows a dependent instruction through the pipeline. A single port snapshot never shows it. The bench drives the stage fields cycle by cycle: the producer in EX, then a bubble in EX with the producer in MEM, then the producer gone to writeback. It counts the stall cycles the consumer sees. The forwarding-mode load case uses the same walk. Other corner cases, such as a match on register 0, a matching index with its use flag clear, and a producer with its write enable clear, sit as rows in the vector table so that each one isolates a single reason not to stall.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Hazard handling policy, selected by the one-bit mode input.
    typedef enum logic {
        POL_STALL_ONLY = 1'b0,
        POL_FORWARD    = 1'b1
    } policy_e;

    // Per-stage hazard summary produced by the comparators.
    typedef struct packed {
        logic ex_dep;     // some used source depends on the EX producer
        logic mem_dep;    // some used source depends on the MEM producer
        logic ex_is_load; // EX producer is a load
    } hazard_t;

    // Front-end hold controls.
    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } hold_t;

    function automatic logic hz_must_stall(policy_e pol, hazard_t hz);
        logic stall;
        if (pol == POL_STALL_ONLY)
            stall = hz.ex_dep | hz.mem_dep;
        else
            stall = hz.ex_dep & hz.ex_is_load;
        return stall;
    endfunction

    function automatic hold_t hz_hold(logic stall);
        hold_t h;
        h.pc_we   = ~stall;
        h.ifid_we = ~stall;
        h.bubble  = stall;
        return h;
    endfunction

endpackage

// File: rtl/hz_src_match.sv
// One comparator: does a single decode source depend on a single producer?
module hz_src_match #(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] src,
    input  logic             src_used,
    input  logic [IDX_W-1:0] dst,
    input  logic             dst_wen,
    output logic             dep
);
    localparam logic [IDX_W-1:0] ZERO_REG = '0;

    always_comb begin
        dep = src_used && dst_wen && (src != ZERO_REG) && (src == dst);
    end
endmodule

// File: rtl/hz_policy.sv
// Reduces the comparator matrix and applies the selected policy.
module hz_policy
    import hz_pkg::*;
#(
    parameter int unsigned NUM_SRC = 2
) (
    input  policy_e            mode,
    input  logic [NUM_SRC-1:0] ex_hits,
    input  logic [NUM_SRC-1:0] mem_hits,
    input  logic               ex_load,
    output hold_t              hold
);
    hazard_t hz;

    always_comb begin
        hz.ex_dep     = |ex_hits;
        hz.mem_dep    = |mem_hits;
        hz.ex_is_load = ex_load;
        hold          = hz_hold(hz_must_stall(mode, hz));
    end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             policy_mode,
    input  logic [IDX_W-1:0] src_a,
    input  logic             src_a_used,
    input  logic [IDX_W-1:0] src_b,
    input  logic             src_b_used,
    input  logic [IDX_W-1:0] ex_dst,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             mem_wen,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_bubble
);
    localparam int unsigned NUM_SRC  = 2;
    localparam int unsigned NUM_PROD = 2;   // index 0 = EX, 1 = MEM

    logic [NUM_SRC-1:0][IDX_W-1:0]  srcs;
    logic [NUM_SRC-1:0]             srcs_used;
    logic [NUM_PROD-1:0][IDX_W-1:0] dsts;
    logic [NUM_PROD-1:0]            dsts_wen;
    logic [NUM_PROD-1:0][NUM_SRC-1:0] hits;
    hold_t                          hold;

    assign srcs      = {src_b, src_a};
    assign srcs_used = {src_b_used, src_a_used};
    assign dsts      = {mem_dst, ex_dst};
    assign dsts_wen  = {mem_wen, ex_wen};

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            hz_src_match #(.IDX_W(IDX_W)) u_match (
                .src      (srcs[s]),
                .src_used (srcs_used[s]),
                .dst      (dsts[p]),
                .dst_wen  (dsts_wen[p]),
                .dep      (hits[p][s])
            );
        end
    end

    hz_policy #(.NUM_SRC(NUM_SRC)) u_policy (
        .mode     (policy_e'(policy_mode)),
        .ex_hits  (hits[0]),
        .mem_hits (hits[1]),
        .ex_load  (ex_load),
        .hold     (hold)
    );

    assign pc_we       = hold.pc_we;
    assign ifid_we     = hold.ifid_we;
    assign idex_bubble = hold.bubble;
endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk #(
    parameter int unsigned IDX_W = 5
) (
    input logic             policy_mode,
    input logic [IDX_W-1:0] src_a,
    input logic             src_a_used,
    input logic [IDX_W-1:0] src_b,
    input logic             src_b_used,
    input logic [IDX_W-1:0] ex_dst,
    input logic             ex_wen,
    input logic             ex_load,
    input logic [IDX_W-1:0] mem_dst,
    input logic             mem_wen,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             idex_bubble
);
    logic a_live, b_live, ex_ld_dep;

    always_comb begin
        a_live    = src_a_used && (src_a != '0);
        b_live    = src_b_used && (src_b != '0);
        ex_ld_dep = ex_wen && ex_load &&
                    ((a_live && src_a == ex_dst) || (b_live && src_b == ex_dst));

        AST_HOLD_PAIR: assert (pc_we == ifid_we && idex_bubble == !pc_we); // R9
        if (!a_live && !b_live)
            AST_NO_LIVE_SRC: assert (pc_we); // R4
        if (!ex_wen && !mem_wen)
            AST_NO_WRITER: assert (pc_we); // R6
        if (policy_mode && !ex_load)
            AST_FWD_NONLOAD_FREE: assert (pc_we); // R8
        if (policy_mode && ex_ld_dep)
            AST_FWD_LOAD_HOLD: assert (idex_bubble); // R7
    end
endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/hz_stall_ctrl_bench.sv
module hz_stall_ctrl_bench;
    localparam int IDX_W = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic             policy_mode;
    logic [IDX_W-1:0] src_a, src_b, ex_dst, mem_dst;
    logic             src_a_used, src_b_used, ex_wen, ex_load, mem_wen;
    logic             pc_we, ifid_we, idex_bubble;

    int errors = 0;
    int checks = 0;

    hz_stall_ctrl #(.IDX_W(IDX_W)) u_hz_stall_ctrl (.*);

    typedef struct packed {
        logic [3:0] req;
        logic       mode;
        logic       ua;
        logic [4:0] sa;
        logic       ub;
        logic [4:0] sb;
        logic       exw;
        logic       exl;
        logic [4:0] exd;
        logic       memw;
        logic [4:0] memd;
        logic       stall;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0, 1'b1, 5'd3,  1'b0, 5'd0,  1'b1, 1'b0, 5'd3,  1'b0, 5'd0,  1'b1}, // R1 src_a vs EX
        '{4'd1, 1'b0, 1'b0, 5'd3,  1'b1, 5'd7,  1'b1, 1'b0, 5'd7,  1'b0, 5'd0,  1'b1}, // R1 src_b vs EX
        '{4'd2, 1'b0, 1'b1, 5'd9,  1'b1, 5'd2,  1'b0, 1'b0, 5'd0,  1'b1, 5'd9,  1'b1}, // R2 src_a vs MEM
        '{4'd2, 1'b0, 1'b1, 5'd1,  1'b1, 5'd12, 1'b1, 1'b0, 5'd4,  1'b1, 5'd12, 1'b1}, // R2 src_b vs MEM
        '{4'd3, 1'b0, 1'b1, 5'd4,  1'b1, 5'd5,  1'b1, 1'b0, 5'd6,  1'b1, 5'd7,  1'b0}, // R3 no match
        '{4'd4, 1'b0, 1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 5'd0,  1'b0}, // R4 zero register
        '{4'd5, 1'b0, 1'b0, 5'd8,  1'b0, 5'd8,  1'b1, 1'b1, 5'd8,  1'b1, 5'd8,  1'b0}, // R5 unused sources
        '{4'd6, 1'b0, 1'b1, 5'd10, 1'b1, 5'd11, 1'b0, 1'b0, 5'd10, 1'b0, 5'd11, 1'b0}, // R6 no write enable
        '{4'd7, 1'b1, 1'b1, 5'd6,  1'b0, 5'd0,  1'b1, 1'b1, 5'd6,  1'b0, 5'd0,  1'b1}, // R7 load vs src_a
        '{4'd7, 1'b1, 1'b1, 5'd2,  1'b1, 5'd13, 1'b1, 1'b1, 5'd13, 1'b1, 5'd2,  1'b1}, // R7 load vs src_b
        '{4'd8, 1'b1, 1'b1, 5'd6,  1'b1, 5'd6,  1'b1, 1'b0, 5'd6,  1'b0, 5'd0,  1'b0}, // R8 ALU in EX
        '{4'd8, 1'b1, 1'b1, 5'd14, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 5'd14, 1'b0}, // R8 MEM match
        '{4'd4, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0}, // R4 load to x0
        '{4'd5, 1'b1, 1'b0, 5'd6,  1'b0, 5'd6,  1'b1, 1'b1, 5'd6,  1'b0, 5'd0,  1'b0}  // R5 forwarding
    };

    task automatic drive(input vec_t v);
        policy_mode = v.mode;
        src_a_used  = v.ua;  src_a  = v.sa;
        src_b_used  = v.ub;  src_b  = v.sb;
        ex_wen      = v.exw; ex_load = v.exl; ex_dst = v.exd;
        mem_wen     = v.memw; mem_dst = v.memd;
    endtask

    task automatic check_hold(input string req, input logic exp_stall);
        checks++;
        if (pc_we !== !exp_stall || ifid_we !== !exp_stall || idex_bubble !== exp_stall) begin
            errors++;
            $display("FAIL %s: pc_we=%b ifid_we=%b bubble=%b expected pc_we=%b ifid_we=%b bubble=%b",
                     req, pc_we, ifid_we, idex_bubble, !exp_stall, !exp_stall, exp_stall);
        end
    endtask

    task automatic check_count(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: stall cycles %0d expected %0d", req, got, exp);
        end
    endtask

    initial begin
        drive('0);
        #200000;
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int stalls;
        drive('0);
        @(negedge clk); #1;
        check_hold("R3 idle pipeline", 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check_hold($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].stall);
        end

        // R10 stall-only: producer writes x5, consumer reads x5 right behind it.
        stalls = 0;
        @(negedge clk);
        drive('0);
        src_a_used = 1'b1; src_a = 5'd5;
        ex_wen = 1'b1; ex_dst = 5'd5;                  // producer in EX
        #1; if (idex_bubble) stalls++;
        check_hold("R10 stall-only cycle 1", 1'b1);
        @(negedge clk);
        ex_wen = 1'b0; ex_dst = 5'd0;                  // bubble in EX
        mem_wen = 1'b1; mem_dst = 5'd5;                // producer in MEM
        #1; if (idex_bubble) stalls++;
        check_hold("R10 stall-only cycle 2", 1'b1);
        @(negedge clk);
        mem_wen = 1'b0; mem_dst = 5'd0;                // producer in WB
        #1; if (idex_bubble) stalls++;
        check_hold("R10 stall-only cycle 3", 1'b0);
        check_count("R10 stall-only total", stalls, 2);

        // R10 forwarding: load into x9, consumer reads x9 through src_b.
        stalls = 0;
        @(negedge clk);
        drive('0);
        policy_mode = 1'b1;
        src_b_used = 1'b1; src_b = 5'd9;
        ex_wen = 1'b1; ex_load = 1'b1; ex_dst = 5'd9;
        #1; if (idex_bubble) stalls++;
        @(negedge clk);
        ex_wen = 1'b0; ex_load = 1'b0; ex_dst = 5'd0;
        mem_wen = 1'b1; mem_dst = 5'd9;
        #1; if (idex_bubble) stalls++;
        check_hold("R10 forwarding after load", 1'b0);
        check_count("R10 forwarding total", stalls, 1);

        // R9: outputs stay consistent after a mode flip with a live hazard.
        @(negedge clk);
        policy_mode = 1'b0;
        #1;
        check_hold("R9 mode flip to stall-only", 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule